// File: doc/BRIEF.md
# Addend-Driven Precision Time Counter

This block keeps a 64-bit system time for a precision time protocol clock. On every clock a programmable 32-bit addend is summed into a 32-bit fractional phase register. Each carry out of that sum advances the system time by one count, and one count stands for 32 ns. The carry rate is therefore addend / 2^32 per clock. With a 50 MHz clock and the nominal addend 0xA0000000, the time advances exactly once every 32 ns. Software trims the frequency by rewriting the addend. It corrects the phase by reading the time, changing it and writing it back.

The time is reached through a simple 32-bit register bus as two words. A read of the low word freezes the high word in a shadow copy, so the high-word read that follows belongs to the same instant. A write of the low word is only staged. The next high-word write loads both halves into the counter in one cycle. The low word carries into the high word at a programmable limit. This limit can only be changed while a separate unlock register is set, and setting it to all ones makes the 64-bit count continuous. A control bit holds the timing logic in reset while it is set. The live time is also driven out on a port for neighbouring logic.

Top module: `ptp_addend_clock`

## Requirements
- R1: After reset the following hold: control reads 0, addend reads 0xA0000000, limit reads 0x7FFFFFFF, unlock reads 0, and the time and phase are 0.
- R2: Each clock the addend is added modulo 2^32 into the phase. Each carry out advances the time by exactly one count. After K clocks from phase P, the phase is (P + K·A) mod 2^32 and the time has advanced floor((P + K·A) / 2^32) counts. An addend of 0 freezes both.
- R3: A bus read of the time-low word (offset 3) returns the low word and copies the high word into a shadow register. Reads of the time-high word (offset 4) return that shadow, even after the live high word has moved on.
- R4: A write to time-low only stages the value and leaves the running time untouched. A later write to time-high loads {written high, staged low} into the time in one cycle.
- R5: The phase register (offset 2) is readable, and a write to it loads the phase directly.
- R6: While bit 0 of the control register (offset 0) is 1, the time, phase, staged low word and shadow stay at 0, and time writes are ignored. Addend and limit keep their values. Once the bit is cleared the counter resumes from 0.
- R7: When the time is advanced with the low word equal to the limit (offset 6) or to 0xFFFFFFFF, the low word becomes 0 and the high word increments. Otherwise only the low word increments.
- R8: Writes to the limit take effect only while the unlock register (offset 5, bit 0) reads 1. Otherwise the limit is unchanged.
- R9: With the limit set to 0xFFFFFFFF through the unlock sequence, the low word counts through 0x7FFFFFFF without a carry and wraps only from 0xFFFFFFFF.
- R10: The register map is: 0 control, 1 addend, 2 phase, 3 time-low, 4 time-high, 5 unlock, 6 limit. Every other address reads 0 and ignores writes. Read data appears on the bus one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sys_time | output | 64 | Live system time in counts |

## Verification
The bench counts the clocks an addend is active and predicts phase and time from P + K·A. A design that added on the wrong edge, or dropped the carry, ends one count off. Coherent reads are checked across a live low-word wrap. A design that read the high word directly would return the incremented value there. Staged writes are checked against the frozen time, which a design that committed the low word at once would change. The carry limit is checked at its default, after a locked write and after the unlock sequence. A design with a misplaced compare would wrap early, or not at all, at 0x7FFFFFFF.

// File: rtl/ptpclk_pkg.sv
package ptpclk_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 2 * WORD_W;
  localparam logic [WORD_W-1:0] ADDEND_NOMINAL = 32'hA000_0000;
  localparam logic [WORD_W-1:0] LO_LIMIT_DEFAULT = 32'h7FFF_FFFF;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_ADDEND = 3'd1,
    SEL_FRAC   = 3'd2,
    SEL_TLO    = 3'd3,
    SEL_THI    = 3'd4,
    SEL_UNLOCK = 3'd5,
    SEL_LIMIT  = 3'd6,
    SEL_NONE   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/ptpclk_rst_sync.sv
module ptpclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      assign sync_d = 1'b1;
    end else begin : g_chain
      assign sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ptpclk_frac_acc.sv
module ptpclk_frac_acc #(
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr,
  input  logic [FRAC_W-1:0] wval,
  input  logic [FRAC_W-1:0] addend,
  output logic [FRAC_W-1:0] frac_q,
  output logic              carry
);
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] frac_d;

  always_comb begin
    sum = {1'b0, frac_q} + {1'b0, addend};
    if (clr)     frac_d = '0;
    else if (wr) frac_d = wval;
    else         frac_d = sum[FRAC_W-1:0];
    carry = sum[FRAC_W] & ~clr & ~wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frac_q <= '0;
    else        frac_q <= frac_d;
  end

  // R5: a direct phase write lands unchanged
  assert_frac_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> (frac_q == $past(wval)));

  // R2: a zero addend never produces a carry
  assert_zero_addend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addend == '0) |-> !carry);

  // R6: clear empties the phase
  assert_frac_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (frac_q == '0));
endmodule

// File: rtl/ptpclk_time_cnt.sv
module ptpclk_time_cnt #(
  parameter int unsigned LO_W = 32,
  parameter int unsigned HI_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 inc,
  input  logic                 load,
  input  logic [HI_W+LO_W-1:0] load_val,
  input  logic [LO_W-1:0]      lo_limit,
  output logic [HI_W+LO_W-1:0] time_q
);
  localparam int unsigned TW = HI_W + LO_W;

  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            lo_wrap;
  logic [TW-1:0]   time_d;
  logic            time_en;

  assign lo_q = time_q[LO_W-1:0];
  assign hi_q = time_q[TW-1:LO_W];

  always_comb begin
    lo_wrap = (lo_q == lo_limit) || (lo_q == {LO_W{1'b1}});
    time_en = clr | load | inc;
    if (clr)          time_d = '0;
    else if (load)    time_d = load_val;
    else if (lo_wrap) time_d = {hi_q + 1'b1, {LO_W{1'b0}}};
    else              time_d = {hi_q, lo_q + 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       time_q <= '0;
    else if (time_en) time_q <= time_d;
  end

  // R2: without a carry, load or clear the time holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && !inc) |=> $stable(time_q));

  // R7: advancing at the limit clears low and bumps high
  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && inc && lo_q == lo_limit) |=>
      (time_q[LO_W-1:0] == '0 && time_q[TW-1:LO_W] == $past(hi_q) + 1'b1));

  // R4: a commit loads both halves at once
  assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (time_q == $past(load_val)));
endmodule

// File: rtl/ptpclk_bus_regs.sv
module ptpclk_bus_regs
  import ptpclk_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 4,
  parameter logic [WORD_W-1:0] ADDEND_RST = ADDEND_NOMINAL,
  parameter logic [WORD_W-1:0] LIMIT_RST  = LO_LIMIT_DEFAULT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] frac_q,
  input  logic [TIME_W-1:0] time_q,
  output logic              soft_clr,
  output logic [WORD_W-1:0] addend_q,
  output logic [WORD_W-1:0] limit_q,
  output logic              frac_wr,
  output logic              time_load,
  output logic [TIME_W-1:0] time_load_val,
  output logic [WORD_W-1:0] bus_rdata
);
  reg_sel_e         sel;
  logic             ctrl_q, ctrl_en;
  logic             unlock_q, unlock_en;
  logic             addend_en, limit_en;
  logic [WORD_W-1:0] stage_q, stage_d;
  logic             stage_en;
  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic             shadow_en;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic             rd_lo;

  // decode and next state
  always_comb begin
    sel = (bus_addr < ADDR_W'(7)) ? reg_sel_e'(bus_addr[2:0]) : SEL_NONE;
    rd_lo     = bus_rd && (sel == SEL_TLO);
    ctrl_en   = bus_wr && (sel == SEL_CTRL);
    addend_en = bus_wr && (sel == SEL_ADDEND);
    unlock_en = bus_wr && (sel == SEL_UNLOCK);
    limit_en  = bus_wr && (sel == SEL_LIMIT) && unlock_q;
    frac_wr   = bus_wr && (sel == SEL_FRAC);

    stage_en  = ctrl_q || (bus_wr && (sel == SEL_TLO));
    stage_d   = ctrl_q ? '0 : bus_wdata;
    shadow_en = ctrl_q || rd_lo;
    shadow_d  = ctrl_q ? '0 : time_q[TIME_W-1:WORD_W];

    time_load     = bus_wr && (sel == SEL_THI) && !ctrl_q;
    time_load_val = {bus_wdata, stage_q};

    unique case (sel)
      SEL_CTRL:   rdata_d = {{(WORD_W-1){1'b0}}, ctrl_q};
      SEL_ADDEND: rdata_d = addend_q;
      SEL_FRAC:   rdata_d = frac_q;
      SEL_TLO:    rdata_d = time_q[WORD_W-1:0];
      SEL_THI:    rdata_d = shadow_q;
      SEL_UNLOCK: rdata_d = {{(WORD_W-1){1'b0}}, unlock_q};
      SEL_LIMIT:  rdata_d = limit_q;
      default:    rdata_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= 1'b0;
      unlock_q <= 1'b0;
      addend_q <= ADDEND_RST;
      limit_q  <= LIMIT_RST;
      stage_q  <= '0;
      shadow_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (ctrl_en)   ctrl_q   <= bus_wdata[0];
      if (unlock_en) unlock_q <= bus_wdata[0];
      if (addend_en) addend_q <= bus_wdata;
      if (limit_en)  limit_q  <= bus_wdata;
      if (stage_en)  stage_q  <= stage_d;
      if (shadow_en) shadow_q <= shadow_d;
      if (bus_rd)    rdata_q  <= rdata_d;
    end
  end

  assign soft_clr  = ctrl_q;
  assign bus_rdata = rdata_q;

  // R8: a locked limit never moves
  assert_limit_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock_q |=> $stable(limit_q));

  // R3: the shadow only moves on a low-word read or a soft reset
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !ctrl_q) |=> $stable(shadow_q));

  // R6: no commit escapes while the soft reset is held
  assert_no_load_in_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q |-> !time_load);

  // R10: read data only changes after a read strobe
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: rtl/ptp_addend_clock.sv
module ptp_addend_clock
  import ptpclk_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 4,
  parameter logic [WORD_W-1:0] ADDEND_RST  = ADDEND_NOMINAL,
  parameter logic [WORD_W-1:0] LIMIT_RST   = LO_LIMIT_DEFAULT,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [TIME_W-1:0] sys_time
);
  logic              rst_sync_n;
  logic              soft_clr;
  logic [WORD_W-1:0] addend_q;
  logic [WORD_W-1:0] limit_q;
  logic              frac_wr;
  logic [WORD_W-1:0] frac_q;
  logic              carry;
  logic              time_load;
  logic [TIME_W-1:0] time_load_val;
  logic [TIME_W-1:0] time_q;

  ptpclk_rst_sync #(.STAGES(SYNC_STAGES)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ptpclk_bus_regs #(
    .ADDR_W     (ADDR_W),
    .ADDEND_RST (ADDEND_RST),
    .LIMIT_RST  (LIMIT_RST)
  ) regs_i (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .bus_wr        (bus_wr),
    .bus_rd        (bus_rd),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .frac_q        (frac_q),
    .time_q        (time_q),
    .soft_clr      (soft_clr),
    .addend_q      (addend_q),
    .limit_q       (limit_q),
    .frac_wr       (frac_wr),
    .time_load     (time_load),
    .time_load_val (time_load_val),
    .bus_rdata     (bus_rdata)
  );

  ptpclk_frac_acc #(.FRAC_W(WORD_W)) acc_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (soft_clr),
    .wr     (frac_wr),
    .wval   (bus_wdata),
    .addend (addend_q),
    .frac_q (frac_q),
    .carry  (carry)
  );

  ptpclk_time_cnt #(.LO_W(WORD_W), .HI_W(TIME_W - WORD_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (soft_clr),
    .inc      (carry),
    .load     (time_load),
    .load_val (time_load_val),
    .lo_limit (limit_q),
    .time_q   (time_q)
  );

  assign sys_time = time_q;

  // R6: a held soft reset zeroes time and phase on the next cycle
  assert_soft_reset_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_clr |=> (sys_time == '0 && frac_q == '0));

  // R2: time moves by at most one count per cycle unless loaded or cleared
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!time_load && !soft_clr && !frac_wr) |=>
      (sys_time == $past(sys_time) || sys_time[WORD_W-1:0] == $past(sys_time[WORD_W-1:0]) + 1'b1
       || sys_time[WORD_W-1:0] == '0));
endmodule

// File: tb/ptp_addend_clock_tb.sv
`timescale 1ns/1ps
module ptp_addend_clock_tb_top;
  localparam logic [3:0] A_CTRL = 4'd0, A_ADD = 4'd1, A_FRAC = 4'd2, A_TLO = 4'd3,
                         A_THI = 4'd4, A_UNL = 4'd5, A_LIM = 4'd6;
  localparam int unsigned WATCHDOG_CYC = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [63:0] sys_time;

  int unsigned n_total = 0;
  int unsigned n_bad   = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  ptp_addend_clock dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sys_time(sys_time)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bread(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [63:0] advance(input logic [63:0] t, input logic [31:0] lim,
                                          input int unsigned n);
    for (int unsigned i = 0; i < n; i++) begin
      if (t[31:0] == lim || t[31:0] == 32'hFFFF_FFFF) t = {t[63:32] + 32'd1, 32'd0};
      else t = t + 64'd1;
    end
    return t;
  endfunction

  task automatic set_state(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] fr);
    bwrite(A_ADD, 32'd0);
    bwrite(A_FRAC, fr);
    bwrite(A_TLO, lo);
    bwrite(A_THI, hi);
  endtask

  // addend A is summed on exactly k edges, then the counter is frozen
  task automatic run(input logic [31:0] a, input int unsigned k);
    bwrite(A_ADD, a);
    repeat (k - 1) @(negedge clk);
    bwrite(A_ADD, 32'd0);
  endtask

  task automatic run_and_check(input string tag, input logic [31:0] hi, input logic [31:0] lo,
                               input logic [31:0] fr, input logic [31:0] a,
                               input int unsigned k, input logic [31:0] lim);
    logic [63:0] tot, exp_t;
    logic [31:0] rd;
    set_state(hi, lo, fr);
    run(a, k);
    tot   = {32'd0, fr} + ({32'd0, a} * 64'(k));
    exp_t = advance({hi, lo}, lim, int'(tot[63:32]));
    bread(A_FRAC, rd);
    check({tag, " phase"}, {32'd0, rd}, {32'd0, tot[31:0]});
    check({tag, " time"}, sys_time, exp_t);
  endtask

  initial begin
    logic [31:0] rd, lo_v, fr_v, a_v;
    int unsigned k_v, seed_v;
    seed_v = $urandom(32'd2024);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    check("R1 time in reset", sys_time, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    bread(A_CTRL, rd); check("R1 ctrl", {32'd0, rd}, 64'd0);
    bread(A_ADD, rd);  check("R1 addend", {32'd0, rd}, 64'hA000_0000);
    bread(A_LIM, rd);  check("R1 limit", {32'd0, rd}, 64'h7FFF_FFFF);
    bread(A_UNL, rd);  check("R1 unlock", {32'd0, rd}, 64'd0);

    // R2: nominal addend gives 5 counts in 8 clocks
    run_and_check("R2 nominal", 32'd0, 32'd0, 32'd0, 32'hA000_0000, 8, 32'h7FFF_FFFF);
    // R2: random addends and windows
    for (int i = 0; i < 6; i++) begin
      a_v  = $urandom;
      fr_v = $urandom;
      lo_v = $urandom & 32'h0FFF_FFFF;
      k_v  = 1 + ($urandom % 200);
      run_and_check("R2 random", $urandom, lo_v, fr_v, a_v, k_v, 32'h7FFF_FFFF);
    end

    // R7: default limit wraps low into high
    run_and_check("R7 default wrap", 32'd2, 32'h7FFF_FFFD, 32'h100, 32'hFFFF_FFFF, 5, 32'h7FFF_FFFF);

    // R8: locked write is ignored, unlocked write sticks
    bwrite(A_LIM, 32'hFFFF_FFFF);
    bread(A_LIM, rd); check("R8 locked write", {32'd0, rd}, 64'h7FFF_FFFF);
    bwrite(A_UNL, 32'd1);
    bwrite(A_LIM, 32'hFFFF_FFFF);
    bwrite(A_UNL, 32'd0);
    bread(A_LIM, rd); check("R8 unlocked write", {32'd0, rd}, 64'hFFFF_FFFF);
    bread(A_UNL, rd); check("R8 relocked", {32'd0, rd}, 64'd0);
    bwrite(A_LIM, 32'h0000_1234);
    bread(A_LIM, rd); check("R8 locked again", {32'd0, rd}, 64'hFFFF_FFFF);

    // R9: continuous counting through 0x7FFFFFFF and from 0xFFFFFFFF
    run_and_check("R9 mid pass", 32'd7, 32'h7FFF_FFFE, 32'h100, 32'hFFFF_FFFF, 3, 32'hFFFF_FFFF);
    check("R9 mid value", sys_time, {32'd7, 32'h8000_0001});
    run_and_check("R9 top wrap", 32'd7, 32'hFFFF_FFFE, 32'h100, 32'hFFFF_FFFF, 4, 32'hFFFF_FFFF);

    // R3: coherent read across a live low-word wrap
    set_state(32'd5, 32'hFFFF_FF00, 32'h0001_0000);
    bwrite(A_ADD, 32'hFFFF_FFFF);
    bread(A_TLO, rd); check("R3 low word", {32'd0, rd}, 64'hFFFF_FF00);
    repeat (300) @(negedge clk);
    check("R3 live high moved", {32'd0, sys_time[63:32]}, 64'd6);
    bread(A_THI, rd); check("R3 shadow high", {32'd0, rd}, 64'd5);
    bread(A_TLO, rd);
    bread(A_THI, rd); check("R3 fresh high", {32'd0, rd}, 64'd6);
    bwrite(A_ADD, 32'd0);

    // R4: staged low then commit
    set_state(32'd1, 32'h11, 32'd0);
    bwrite(A_TLO, 32'h0000_DEAD);
    check("R4 staged only", sys_time, {32'd1, 32'h11});
    bread(A_TLO, rd); check("R4 low unchanged", {32'd0, rd}, 64'h11);
    bwrite(A_THI, 32'h22);
    check("R4 commit", sys_time, {32'h22, 32'h0000_DEAD});

    // R5: phase read back
    fr_v = $urandom;
    bwrite(A_FRAC, fr_v);
    bread(A_FRAC, rd); check("R5 phase readback", {32'd0, rd}, {32'd0, fr_v});

    // R6: soft reset
    bwrite(A_ADD, 32'hA000_0000);
    repeat (10) @(negedge clk);
    bwrite(A_CTRL, 32'd1);
    repeat (2) @(negedge clk);
    check("R6 time cleared", sys_time, 64'd0);
    bread(A_FRAC, rd); check("R6 phase cleared", {32'd0, rd}, 64'd0);
    bread(A_ADD, rd);  check("R6 addend kept", {32'd0, rd}, 64'hA000_0000);
    bread(A_LIM, rd);  check("R6 limit kept", {32'd0, rd}, 64'hFFFF_FFFF);
    bread(A_CTRL, rd); check("R6 ctrl readback", {32'd0, rd}, 64'd1);
    bread(A_THI, rd);  check("R6 shadow cleared", {32'd0, rd}, 64'd0);
    bwrite(A_TLO, 32'h55);
    bwrite(A_THI, 32'h66);
    check("R6 write ignored", sys_time, 64'd0);
    bwrite(A_CTRL, 32'd0);
    repeat (20) @(negedge clk);
    check("R6 resume", sys_time, 64'd12);

    // R10: unmapped addresses
    bwrite(4'd9, 32'h5555_5555);
    bread(4'd9, rd);  check("R10 unmapped read", {32'd0, rd}, 64'd0);
    bread(4'd7, rd);  check("R10 addr 7 read", {32'd0, rd}, 64'd0);
    bread(A_ADD, rd); check("R10 addend untouched", {32'd0, rd}, 64'hA000_0000);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end
endmodule